// File: doc/BRIEF.md
# Six-Channel Conversion Result Buffer

This block is the digital back end of a six-channel, simultaneous-sampling converter. The six channels form three pairs (A, B, C), and each pair has a channel 0 and a channel 1. Each pair has its own active-low hold strobe. A falling hold edge captures the pair's two sample values, which stand in for the analog front end and arrive on a wide input bus. A per-pair cycle counter then models the fixed acquisition-plus-conversion time. At the end of that time the result pair is committed to storage and an end-of-conversion pulse is raised for that pair.

A 3-bit mode/address input selects how reads return data. Values 0 to 5 address a single channel: A0, A1, B0, B1, C0 and C1 are channel indices 0 to 5, so index = 2·pair + sub-channel. Value 6 is a cycle mode in which successive data reads walk through all six channels. Value 7 is a FIFO mode in which results come back in the order the hold strobes arrived. In FIFO mode one pair can fill all six slots. Each read strobe returns one 16-bit word: either a data word or, when the status select is high, a status word. Both come with a data-valid flag.

Top module: `conv_result_buffer`

## Requirements
- R1: While reset (active low) is held, `dataOut` reads 0 and `dataValid` and `eoc` read low. After reset every channel is empty: a fixed-mode read returns data 0 with `dataValid` low.
- R2: `eoc[p]` is high for exactly one cycle. That cycle is the one that follows the 20th clock edge after the edge that first samples `holdN[p]` low. From that same cycle the pair's two results are readable.
- R3: A falling `holdN[p]` while pair p is still converting is ignored. It neither restarts the count nor replaces the captured samples, and the next `eoc[p]` can come no earlier than 21 cycles after the previous one.
- R4: Holds asserted on the same clock for several pairs produce their `eoc` bits in the same cycle, and all six channels are sampled together.
- R5: In fixed mode (`modeSel` 0 to 5), a data read returns channel `modeSel`. `dataValid` is 1 on the first read after the channel was written and 0 on any repeat read, because a data read clears that channel's valid bit.
- R6: In cycle mode (`modeSel` = 6), each data read returns the channel at a pointer and then advances it. The pointer runs 0, 1, ... 5 and wraps back to 0. Reset sets the pointer to 0.
- R7: In FIFO mode (`modeSel` = 7), data reads return results in completion order. Within a pair, channel 0 comes before channel 1. Pairs finishing on the same clock are ordered A, B, C. A read of an empty FIFO returns data 0 with `dataValid` 0.
- R8: The FIFO holds six entries and only records results that complete while FIFO mode is selected. A pair result that finds fewer than two free entries is dropped whole and sets a sticky overflow flag, which only reset clears.
- R9: A status read returns the following fields, and does not consume or advance anything: bits [2:0] give the channel the next data read would return (FIFO head, or 0 when the FIFO is empty); bit 3 gives that word's valid flag; bit 4 gives the overflow flag; bits [15:5] are 0.
- R10: Reset aborts conversions in progress, so no `eoc` and no result follow. A hold held low across the release of reset starts nothing until it rises and falls again.
- R11: `dataOut` and `dataValid` change only on a clock edge that samples `rdStrobe` high, and they hold their value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| holdN | input | 3 | Active-low hold strobes, bit p for pair p (A=0, B=1, C=2) |
| sampleData | input | 96 | Six 16-bit sample values, channel c at bits [16c+15:16c] |
| modeSel | input | 3 | 0 to 5 fixed channel, 6 cycle mode, 7 FIFO mode |
| rdStrobe | input | 1 | Read request, one word per clock it is high |
| statusSel | input | 1 | With rdStrobe: 1 returns the status word, 0 returns data |
| dataOut | output | 16 | Read word, registered |
| dataValid | output | 1 | Valid flag of the returned word |
| eoc | output | 3 | Per-pair one-cycle end-of-conversion pulse |

## Verification
An off-by-one in a conversion counter shows up as an `eoc` pulse one clock early or late, and the first conversion after reset exposes it. A wrong busy flag shows up as a second `eoc` about 21 cycles too soon, or as a result carrying the later sample. A wrong FIFO write index or pop shift surfaces on the next few data reads in FIFO mode, as a swapped or repeated channel order. A stale valid bit or pointer surfaces within one read as a wrong `dataValid` or the wrong word. A lost overflow flag appears in the very next status word.

// File: rtl/crb_pkg.sv
package crb_pkg;
  localparam int DATA_W    = 16;
  localparam int NUM_PAIRS = 3;
  localparam int NUM_CH    = 2 * NUM_PAIRS;
  localparam int CH_W      = 3;

  localparam logic [CH_W-1:0] MODE_CYCLE = 3'd6;
  localparam logic [CH_W-1:0] MODE_FIFO  = 3'd7;

  localparam int STAT_VALID_BIT = 3;
  localparam int STAT_OVF_BIT   = 4;

  typedef struct packed {
    logic [NUM_PAIRS-1:0] capture;    // latch the pair's samples
    logic [NUM_PAIRS-1:0] commit;     // conversion finished, store result pair
    logic                 readData;
    logic                 readStatus;
    logic                 fifoMode;
    logic [CH_W-1:0]      readCh;     // addressed channel for fixed/cycle reads
  } ctrlStrobes_t;
endpackage

// File: rtl/crb_ctrl.sv
module crb_ctrl
  import crb_pkg::*;
#(
  parameter int CONV_CYCLES = 20
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_PAIRS-1:0] holdN,
  input  logic [CH_W-1:0]      modeSel,
  input  logic                 rdStrobe,
  input  logic                 statusSel,
  output ctrlStrobes_t         strobes,
  output logic [NUM_PAIRS-1:0] eoc
);
  localparam int CNT_W = $clog2(CONV_CYCLES + 1);

  logic [NUM_PAIRS-1:0] holdPrev;
  logic [NUM_PAIRS-1:0] startVec;
  logic [NUM_PAIRS-1:0] doneVec;
  logic [CH_W-1:0]      cyclePtr;

  // Reset treats the previous hold level as low, so a hold kept low
  // through reset release produces no falling edge.
  always_ff @(posedge clk) begin
    if (!rstN) holdPrev <= '0;
    else       holdPrev <= holdN;
  end

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : gen_pair
    logic             busyL;
    logic [CNT_W-1:0] cntL;

    assign startVec[p] = holdPrev[p] & ~holdN[p] & ~busyL;
    assign doneVec[p]  = busyL && (cntL == CNT_W'(CONV_CYCLES));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        busyL <= 1'b0;
        cntL  <= '0;
      end else if (doneVec[p]) begin
        busyL <= 1'b0;
      end else if (startVec[p]) begin
        busyL <= 1'b1;
        cntL  <= CNT_W'(1);
      end else if (busyL) begin
        cntL  <= cntL + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) eoc <= '0;
    else       eoc <= doneVec;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cyclePtr <= '0;
    end else if (rdStrobe && !statusSel && modeSel == MODE_CYCLE) begin
      cyclePtr <= (cyclePtr == CH_W'(NUM_CH - 1)) ? '0 : cyclePtr + CH_W'(1);
    end
  end

  always_comb begin
    strobes.capture    = startVec;
    strobes.commit     = doneVec;
    strobes.readData   = rdStrobe & ~statusSel;
    strobes.readStatus = rdStrobe & statusSel;
    strobes.fifoMode   = (modeSel == MODE_FIFO);
    strobes.readCh     = (modeSel == MODE_CYCLE) ? cyclePtr : modeSel;
  end
endmodule

// File: rtl/crb_datapath.sv
module crb_datapath
  import crb_pkg::*;
#(
  parameter int FIFO_DEPTH = 6
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [NUM_CH*DATA_W-1:0] sampleData,
  input  ctrlStrobes_t             strobes,
  output logic [DATA_W-1:0]        dataOut,
  output logic                     dataValid
);
  localparam int LVL_W = $clog2(FIFO_DEPTH + 1);

  logic [NUM_CH*DATA_W-1:0] pendFlat;
  logic [NUM_CH*DATA_W-1:0] resFlat;
  logic [NUM_CH-1:0]        chValid;

  for (genvar c = 0; c < NUM_CH; c++) begin : gen_ch
    logic [DATA_W-1:0] pendL;
    logic [DATA_W-1:0] resL;
    logic              validL;

    always_ff @(posedge clk) begin
      if (!rstN)                     pendL <= '0;
      else if (strobes.capture[c/2]) pendL <= sampleData[c*DATA_W +: DATA_W];
    end

    always_ff @(posedge clk) begin
      if (!rstN)                    resL <= '0;
      else if (strobes.commit[c/2]) resL <= pendL;
    end

    always_ff @(posedge clk) begin
      if (!rstN)
        validL <= 1'b0;
      else if (strobes.commit[c/2])
        validL <= 1'b1;
      else if (strobes.readData && !strobes.fifoMode && strobes.readCh == CH_W'(c))
        validL <= 1'b0;
    end

    assign pendFlat[c*DATA_W +: DATA_W] = pendL;
    assign resFlat[c*DATA_W +: DATA_W]  = resL;
    assign chValid[c]                   = validL;
  end

  // Shift-down FIFO: slot 0 is the head.
  logic [DATA_W-1:0] fifoData [FIFO_DEPTH];
  logic [CH_W-1:0]   fifoCh   [FIFO_DEPTH];
  logic [LVL_W-1:0]  fifoCount;
  logic [DATA_W-1:0] nData    [FIFO_DEPTH];
  logic [CH_W-1:0]   nCh      [FIFO_DEPTH];
  logic [LVL_W-1:0]  nCount;
  logic              overflow;
  logic              ovfSet;
  logic              popNow;
  int                fifoLevel;

  assign popNow = strobes.readData && strobes.fifoMode && (fifoCount != '0);

  always_comb begin
    nData     = fifoData;
    nCh       = fifoCh;
    ovfSet    = 1'b0;
    fifoLevel = int'(fifoCount);
    if (popNow) begin
      for (int s = 1; s < FIFO_DEPTH; s++) begin
        nData[s-1] = fifoData[s];
        nCh[s-1]   = fifoCh[s];
      end
      fifoLevel = fifoLevel - 1;
    end
    for (int p = 0; p < NUM_PAIRS; p++) begin
      if (strobes.fifoMode && strobes.commit[p]) begin
        if (fifoLevel + 2 <= FIFO_DEPTH) begin
          for (int s = 0; s < FIFO_DEPTH; s++) begin
            if (s == fifoLevel) begin
              nData[s] = pendFlat[(2*p)*DATA_W +: DATA_W];
              nCh[s]   = CH_W'(2*p);
            end
            if (s == fifoLevel + 1) begin
              nData[s] = pendFlat[(2*p+1)*DATA_W +: DATA_W];
              nCh[s]   = CH_W'(2*p+1);
            end
          end
          fifoLevel = fifoLevel + 2;
        end else begin
          ovfSet = 1'b1;
        end
      end
    end
    nCount = LVL_W'(fifoLevel);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fifoCount <= '0;
      overflow  <= 1'b0;
      for (int s = 0; s < FIFO_DEPTH; s++) begin
        fifoData[s] <= '0;
        fifoCh[s]   <= '0;
      end
    end else begin
      fifoCount <= nCount;
      fifoData  <= nData;
      fifoCh    <= nCh;
      if (ovfSet) overflow <= 1'b1;
    end
  end

  // Read word selection.
  logic [DATA_W-1:0] fixData;
  logic              fixValid;
  logic              headValid;
  logic [DATA_W-1:0] selData;
  logic              selValid;
  logic [CH_W-1:0]   selCh;
  logic [DATA_W-1:0] statusWord;

  always_comb begin
    fixData  = '0;
    fixValid = 1'b0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (strobes.readCh == CH_W'(c)) begin
        fixData  = resFlat[c*DATA_W +: DATA_W];
        fixValid = chValid[c];
      end
    end
  end

  assign headValid = (fifoCount != '0);

  always_comb begin
    if (strobes.fifoMode) begin
      selData  = headValid ? fifoData[0] : '0;
      selValid = headValid;
      selCh    = headValid ? fifoCh[0] : '0;
    end else begin
      selData  = fixData;
      selValid = fixValid;
      selCh    = strobes.readCh;
    end
    statusWord                 = '0;
    statusWord[CH_W-1:0]       = selCh;
    statusWord[STAT_VALID_BIT] = selValid;
    statusWord[STAT_OVF_BIT]   = overflow;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataOut   <= '0;
      dataValid <= 1'b0;
    end else if (strobes.readData) begin
      dataOut   <= selData;
      dataValid <= selValid;
    end else if (strobes.readStatus) begin
      dataOut   <= statusWord;
      dataValid <= selValid;
    end
  end
endmodule

// File: rtl/conv_result_buffer.sv
module conv_result_buffer
  import crb_pkg::*;
#(
  parameter int CONV_CYCLES = 20,
  parameter int FIFO_DEPTH  = NUM_CH
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [NUM_PAIRS-1:0]     holdN,
  input  logic [NUM_CH*DATA_W-1:0] sampleData,
  input  logic [CH_W-1:0]          modeSel,
  input  logic                     rdStrobe,
  input  logic                     statusSel,
  output logic [DATA_W-1:0]        dataOut,
  output logic                     dataValid,
  output logic [NUM_PAIRS-1:0]     eoc
);
  ctrlStrobes_t strobes;

  crb_ctrl #(.CONV_CYCLES(CONV_CYCLES)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .holdN     (holdN),
    .modeSel   (modeSel),
    .rdStrobe  (rdStrobe),
    .statusSel (statusSel),
    .strobes   (strobes),
    .eoc       (eoc)
  );

  crb_datapath #(.FIFO_DEPTH(FIFO_DEPTH)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .sampleData (sampleData),
    .strobes    (strobes),
    .dataOut    (dataOut),
    .dataValid  (dataValid)
  );
endmodule

// File: rtl/crb_checker.sv
module crb_checker
  import crb_pkg::*;
#(
  parameter int CONV_CYCLES = 20
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [CH_W-1:0]      modeSel,
  input logic                 rdStrobe,
  input logic                 statusSel,
  input logic [DATA_W-1:0]    dataOut,
  input logic                 dataValid,
  input logic [NUM_PAIRS-1:0] eoc
);
  localparam int GAP_W = $clog2(CONV_CYCLES + 3);

  logic rstLowBefore = 1'b0;
  always_ff @(posedge clk) rstLowBefore <= !rstN;

  // R1: outputs cleared while reset is held
  always @(posedge clk) begin
    if (!rstN && rstLowBefore) begin
      p_reset_clear_r1: assert (dataOut == '0 && !dataValid && eoc == '0)
        else $error("reset did not clear outputs");
    end
  end

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : gen_gap
    logic [GAP_W-1:0] gap;
    always_ff @(posedge clk) begin
      if (!rstN)                          gap <= GAP_W'(CONV_CYCLES + 1);
      else if (eoc[p])                    gap <= GAP_W'(1);
      else if (gap < GAP_W'(CONV_CYCLES + 1)) gap <= gap + GAP_W'(1);
    end

    p_eoc_pulse_r2: assert property (@(posedge clk) disable iff (!rstN)
      eoc[p] |=> !eoc[p]);

    p_eoc_gap_r3: assert property (@(posedge clk) disable iff (!rstN)
      eoc[p] |-> gap >= GAP_W'(CONV_CYCLES + 1));
  end

  p_empty_zero_r7: assert property (@(posedge clk) disable iff (!rstN)
    (rdStrobe && !statusSel && modeSel == MODE_FIFO) |=> (dataValid || dataOut == '0));

  p_status_pad_r9: assert property (@(posedge clk) disable iff (!rstN)
    (rdStrobe && statusSel) |=> (dataOut[DATA_W-1:STAT_OVF_BIT+1] == '0));

  p_read_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    !rdStrobe |=> ($stable(dataOut) && $stable(dataValid)));
endmodule

bind conv_result_buffer crb_checker #(.CONV_CYCLES(CONV_CYCLES)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .modeSel   (modeSel),
  .rdStrobe  (rdStrobe),
  .statusSel (statusSel),
  .dataOut   (dataOut),
  .dataValid (dataValid),
  .eoc       (eoc)
);

// File: tb/conv_result_buffer_bench.sv
module conv_result_buffer_bench;
  import crb_pkg::*;

  logic                     clk = 1'b0;
  logic                     rstN;
  logic [NUM_PAIRS-1:0]     holdN;
  logic [NUM_CH*DATA_W-1:0] sampleData;
  logic [CH_W-1:0]          modeSel;
  logic                     rdStrobe;
  logic                     statusSel;
  logic [DATA_W-1:0]        dataOut;
  logic                     dataValid;
  logic [NUM_PAIRS-1:0]     eoc;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  conv_result_buffer u_conv_result_buffer (
    .clk(clk), .rstN(rstN), .holdN(holdN), .sampleData(sampleData),
    .modeSel(modeSel), .rdStrobe(rdStrobe), .statusSel(statusSel),
    .dataOut(dataOut), .dataValid(dataValid), .eoc(eoc)
  );

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic doReset();
    rstN = 1'b0; holdN = '1; rdStrobe = 1'b0; statusSel = 1'b0;
    tick(2);
    rstN = 1'b1;
    tick(1);
  endtask

  function automatic logic [15:0] val(int ch, int k);
    return 16'(16'hA000 + ch * 16'h0111 + k * 16'h0010);
  endfunction

  task automatic setSamples(int k);
    for (int c = 0; c < NUM_CH; c++) sampleData[c*DATA_W +: DATA_W] = val(c, k);
  endtask

  // Hold low for one clock; returns at the negedge after the sampling edge.
  task automatic fire(logic [NUM_PAIRS-1:0] mask);
    holdN = ~mask;
    tick(1);
    holdN = '1;
  endtask

  task automatic readWord(bit st, output logic [15:0] d, output logic v);
    statusSel = st; rdStrobe = 1'b1;
    tick(1);
    rdStrobe = 1'b0; statusSel = 1'b0;
    d = dataOut; v = dataValid;
  endtask

  task automatic testReset();
    logic [15:0] d; logic v;
    rstN = 1'b0; holdN = '1; rdStrobe = 1'b0; statusSel = 1'b0; modeSel = 3'd0;
    setSamples(0);
    tick(3);
    check(dataOut == 0 && !dataValid && eoc == 0, "R1 reset outputs",
          {dataOut, 12'(dataValid), eoc}, 32'h0);
    rstN = 1'b1; tick(1);
    modeSel = 3'd3;
    readWord(1'b0, d, v);
    check(d == 0 && !v, "R1 empty channel after reset", {d, 15'd0, v}, 32'h0);
  endtask

  task automatic testLatency();
    logic [15:0] d; logic v;
    doReset(); modeSel = 3'd2; setSamples(1);
    fire(3'b010);
    tick(19);
    check(eoc == 3'b000, "R2 eoc not early", 32'(eoc), 32'h0);
    tick(1);
    check(eoc == 3'b010, "R2 eoc at 20 cycles", 32'(eoc), 32'h2);
    tick(1);
    check(eoc == 3'b000, "R2 eoc one cycle", 32'(eoc), 32'h0);
    readWord(1'b0, d, v);
    check(d == val(2, 1) && v, "R5 fixed read B0", {d, 15'd0, v}, {val(2, 1), 16'h1});
    readWord(1'b0, d, v);
    check(!v, "R5 repeat read invalid", 32'(v), 32'h0);
    modeSel = 3'd3;
    readWord(1'b0, d, v);
    check(d == val(3, 1) && v, "R5 fixed read B1", {d, 15'd0, v}, {val(3, 1), 16'h1});
  endtask

  task automatic testBusyIgnore();
    logic [15:0] d; logic v;
    bit extra = 1'b0;
    doReset(); modeSel = 3'd0; setSamples(2);
    fire(3'b001);
    tick(4);
    setSamples(3);
    fire(3'b001);
    tick(15);
    check(eoc == 3'b001, "R3 first conversion unaffected", 32'(eoc), 32'h1);
    for (int i = 0; i < 25; i++) begin
      tick(1);
      if (eoc[0]) extra = 1'b1;
    end
    check(!extra, "R3 second hold ignored", 32'(extra), 32'h0);
    readWord(1'b0, d, v);
    check(d == val(0, 2), "R3 first sample kept A0", 32'(d), 32'(val(0, 2)));
    modeSel = 3'd1;
    readWord(1'b0, d, v);
    check(d == val(1, 2), "R3 first sample kept A1", 32'(d), 32'(val(1, 2)));
  endtask

  task automatic testSimulCycle();
    logic [15:0] d; logic v;
    doReset(); modeSel = 3'd0; setSamples(4);
    fire(3'b111);
    tick(20);
    check(eoc == 3'b111, "R4 simultaneous eoc", 32'(eoc), 32'h7);
    modeSel = MODE_CYCLE;
    for (int c = 0; c < NUM_CH; c++) begin
      readWord(1'b0, d, v);
      check(d == val(c, 4) && v, "R6 cycle order", {d, 15'd0, v}, {val(c, 4), 16'h1});
    end
    readWord(1'b0, d, v);
    check(d == val(0, 4) && !v, "R6 wrap to A0", {d, 15'd0, v}, {val(0, 4), 16'h0});
  endtask

  task automatic testFifoOrder();
    logic [15:0] d; logic v;
    int order[6] = '{4, 5, 2, 3, 0, 1};
    doReset(); modeSel = MODE_FIFO; setSamples(5);
    fire(3'b100); tick(1);
    fire(3'b010); tick(1);
    fire(3'b001);
    tick(25);
    readWord(1'b1, d, v);
    check(d == 16'h000C && v, "R9 status head C0", 32'(d), 32'h000C);
    for (int i = 0; i < 6; i++) begin
      readWord(1'b0, d, v);
      check(d == val(order[i], 5) && v, "R7 fifo arrival order",
            {d, 15'd0, v}, {val(order[i], 5), 16'h1});
    end
    readWord(1'b0, d, v);
    check(d == 0 && !v, "R7 empty fifo read", {d, 15'd0, v}, 32'h0);
  endtask

  task automatic testFifoFill();
    logic [15:0] d; logic v;
    doReset(); modeSel = MODE_FIFO;
    for (int k = 0; k < 3; k++) begin
      setSamples(6 + k);
      fire(3'b001);
      tick(22);
    end
    setSamples(9);
    fire(3'b010);
    tick(22);
    readWord(1'b1, d, v);
    check(d == 16'h0018, "R8 overflow flagged, head A0", 32'(d), 32'h0018);
    for (int k = 0; k < 3; k++) begin
      readWord(1'b0, d, v);
      check(d == val(0, 6 + k) && v, "R8 one pair fills fifo ch0", 32'(d), 32'(val(0, 6 + k)));
      readWord(1'b0, d, v);
      check(d == val(1, 6 + k) && v, "R8 one pair fills fifo ch1", 32'(d), 32'(val(1, 6 + k)));
    end
    readWord(1'b0, d, v);
    check(!v, "R8 dropped pair absent", 32'(v), 32'h0);
    readWord(1'b1, d, v);
    check(d == 16'h0010, "R8 overflow sticky", 32'(d), 32'h0010);
    doReset();
    readWord(1'b1, d, v);
    check(d == 16'h0000, "R8 reset clears overflow", 32'(d), 32'h0);
  endtask

  task automatic testResetAbort();
    logic [15:0] d; logic v;
    bit seen = 1'b0;
    doReset(); modeSel = 3'd0; setSamples(10);
    fire(3'b001);
    tick(5);
    holdN = 3'b101; rstN = 1'b0;
    tick(2);
    rstN = 1'b1;
    for (int i = 0; i < 30; i++) begin
      tick(1);
      if (eoc != 0) seen = 1'b1;
    end
    check(!seen, "R10 abort and no start on held hold", 32'(seen), 32'h0);
    readWord(1'b1, d, v);
    check(d == 16'h0000, "R10 no result after abort", 32'(d), 32'h0);
    holdN = '1; tick(1);
    fire(3'b010);
    tick(20);
    check(eoc == 3'b010, "R10 fresh edge starts", 32'(eoc), 32'h2);
  endtask

  task automatic testReadHold();
    logic [15:0] d; logic v;
    doReset(); modeSel = 3'd4; setSamples(11);
    fire(3'b100);
    tick(22);
    readWord(1'b0, d, v);
    tick(3);
    check(dataOut == val(4, 11) && dataValid, "R11 output holds without strobe",
          32'(dataOut), 32'(val(4, 11)));
    modeSel = 3'd5; tick(2);
    check(dataOut == val(4, 11), "R11 mode change alone has no effect",
          32'(dataOut), 32'(val(4, 11)));
  endtask

  initial begin
    holdN = '1; rdStrobe = 1'b0; statusSel = 1'b0; modeSel = '0; rstN = 1'b0;
    sampleData = '0;
    testReset();
    testLatency();
    testBusyIgnore();
    testSimulCycle();
    testFifoOrder();
    testFifoFill();
    testResetAbort();
    testReadHold();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    #(5 * 200000);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule